// File: doc/BRIEF.md
# Programmable Interval Timer Counter Channel

A single 16-bit down-counting timer channel that advances once per cycle of its clock. A byte-wide host port selects one of three behaviours and loads the start count. The count goes in as two writes, low byte first. Each behaviour has its own rules for when counting starts and stops, how the gate input is used, and what level the output pin drives.

The three behaviours are:

- **Terminal-count flag.** The output goes high once the loaded count has run out.
- **Gate-triggered one-shot.** The gate retriggers it, and it drives a low pulse lasting exactly the loaded count.
- **Divide-by-N rate generator.** The gate can pause it and resynchronise it, and it drops the output for one clock in every N clocks.

The host can read the running count at any time, one byte per read, low byte first, without disturbing the counter or the output.

Top module: `pit_channel`

## Requirements
- R1: While rst_ni is low, out_o is 0 and rd_data_o is 0. After reset the channel is in the terminal-count behaviour, idle, with both byte pointers on the low byte.
- R2: A write with wr_sel_i=1 selects the behaviour from wr_data_i[1:0]: 0 is terminal-count, 1 is one-shot, 2 is rate generator. Selecting a behaviour stops counting and returns both byte pointers to the low byte. It also sets out_o low for terminal-count and high for the other two. A value of 3 in wr_data_i[1:0] is ignored, and neither counting nor the output changes.
- R3: Writes with wr_sel_i=0 carry the count, low byte first and high byte second. The load takes effect at the clock edge that takes the high byte. A count of 0 means 65536.
- R4: Terminal-count: at the load edge out_o goes low. The count then drops by one on every clock, and out_o goes high after N clocks and stays high. The count keeps decrementing and wraps past zero.
- R5: Terminal-count: writing only the low byte freezes the count at once. The matching high-byte write restarts counting from the new value with out_o low.
- R6: One-shot: gate_i passes two synchronizer flops. The third clock edge after gate_i is first sampled high drives out_o low, and out_o returns high after N clocks. A gate rise before any count has been loaded is ignored.
- R7: One-shot: a gate rise while the pulse is running reloads the full count, which stretches the low pulse to N clocks from that retrigger.
- R8: One-shot: loading a new count during a pulse leaves that pulse's length unchanged. The new count applies from the next trigger.
- R9: Rate generator: out_o stays high after the behaviour is selected until the first count load, which starts counting. From then on, out_o is low for exactly one clock in every N clocks.
- R10: Rate generator: a count loaded while running leaves the current period unchanged. The next period uses the new value.
- R11: Rate generator: while the synchronized gate is low, counting is held and out_o is high. A synchronized gate rise restarts the period from the loaded count.
- R12: rd_data_o shows the count's low byte. Each rd_en_i pulse toggles to the other byte. The high byte shown is the value captured at the moment the low byte was read. Reads never change the count or out_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter and host clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 1 | 1: behaviour select, 0: count byte |
| wr_data_i | input | 8 | Host write data |
| rd_en_i | input | 1 | Advance the read byte pointer |
| rd_data_o | output | 8 | Count byte selected by the read pointer |
| gate_i | input | 1 | Asynchronous gate input |
| out_o | output | 1 | Timer output pin |

## Verification
The hardest case to reach is a full 65536-clock run from a count of zero in terminal-count mode, followed by a wrap that must not disturb the high output. The stimulus loads zero and lets the channel run for the whole length. A close second is the one-shot retrigger, where the gate edge only acts three clocks late. The stimulus places the second rise in the middle of a running pulse and loads a new count while the output is low. The reference model runs the gate through its own three-deep history, so every delayed edge is compared on the exact clock where it should act.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    MODE_TC      = 2'd0,
    MODE_ONESHOT = 2'd1,
    MODE_RATE    = 2'd2
  } pit_mode_e;
endpackage

// File: rtl/pit_gate_sync.sv
module pit_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic level_o,
  output logic rise_o
);
  logic chain_q [STAGES];
  logic dly_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= 1'b0;
        else         chain_q[s] <= gate_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= 1'b0;
        else         chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) dly_q <= 1'b0;
    else         dly_q <= chain_q[STAGES-1];

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~dly_q;
endmodule

// File: rtl/pit_host_if.sv
module pit_host_if
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output pit_mode_e         mode_o,
  output pit_mode_e         new_mode_o,
  output logic              mode_set_o,
  output logic              lo_wr_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [CNT_W-1:0]  cnt_reg_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  pit_mode_e         mode_q;
  logic              wr_ptr_q, rd_ptr_q;
  logic [BYTE_W-1:0] lo_q, rd_hi_q;
  logic [CNT_W-1:0]  cr_q;
  logic              cnt_wr;

  assign new_mode_o = pit_mode_e'(wr_data_i[1:0]);
  assign mode_set_o = wr_en_i & wr_sel_i & (wr_data_i[1:0] != 2'd3);
  assign cnt_wr     = wr_en_i & ~wr_sel_i;
  assign lo_wr_o    = cnt_wr & ~wr_ptr_q;
  assign load_o     = cnt_wr & wr_ptr_q;
  assign load_val_o = {wr_data_i, lo_q};
  assign mode_o     = mode_q;
  assign cnt_reg_o  = cr_q;
  assign rd_data_o  = rd_ptr_q ? rd_hi_q : cnt_i[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_TC;
      wr_ptr_q <= 1'b0;
      lo_q     <= '0;
      cr_q     <= '0;
    end else if (mode_set_o) begin
      mode_q   <= new_mode_o;
      wr_ptr_q <= 1'b0;
    end else if (cnt_wr) begin
      wr_ptr_q <= ~wr_ptr_q;
      if (!wr_ptr_q) lo_q <= wr_data_i;
      else           cr_q <= load_val_o;
    end
  end

  // high byte frozen when the low byte is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= 1'b0;
      rd_hi_q  <= '0;
    end else if (mode_set_o) begin
      rd_ptr_q <= 1'b0;
    end else if (rd_en_i) begin
      rd_ptr_q <= ~rd_ptr_q;
      if (!rd_ptr_q) rd_hi_q <= cnt_i[CNT_W-1:BYTE_W];
    end
  end

  assert_reserved_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i && wr_data_i[1:0] == 2'd3) |=> $stable(mode_q));

  assert_read_capture_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_ptr_q && !mode_set_o) |=> (rd_data_o == $past(cnt_i[CNT_W-1:BYTE_W])));
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pit_mode_e        mode_i,
  input  pit_mode_e        new_mode_i,
  input  logic             mode_set_i,
  input  logic             lo_wr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cnt_reg_i,
  input  logic             level_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             out_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] ce_q, ce_dec;
  logic             out_q, run_q, armed_q;

  assign ce_dec = ce_q - ONE;
  assign cnt_o  = ce_q;
  assign out_o  = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q    <= '0;
      out_q   <= 1'b0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (mode_set_i) begin
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      out_q   <= (new_mode_i != MODE_TC);
    end else begin
      case (mode_i)
        MODE_TC: begin
          if (load_i) begin
            ce_q  <= load_val_i;
            out_q <= 1'b0;
            run_q <= 1'b1;
          end else if (lo_wr_i) begin
            run_q <= 1'b0;
          end else if (run_q) begin
            ce_q <= ce_dec;
            if (ce_q == ONE) out_q <= 1'b1;
          end
        end
        MODE_ONESHOT: begin
          if (load_i) armed_q <= 1'b1;
          if (rise_i && armed_q) begin
            ce_q  <= cnt_reg_i;
            out_q <= 1'b0;
            run_q <= 1'b1;
          end else if (run_q) begin
            ce_q <= ce_dec;
            if (ce_q == ONE) out_q <= 1'b1;
          end
        end
        MODE_RATE: begin
          if (load_i && !run_q) begin
            ce_q  <= load_val_i;
            run_q <= 1'b1;
          end else if (run_q) begin
            if (!level_i) begin
              out_q <= 1'b1;
            end else if (rise_i || ce_q == ONE) begin
              ce_q  <= cnt_reg_i;
              out_q <= 1'b1;
            end else begin
              ce_q  <= ce_dec;
              out_q <= (ce_q != TWO);
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_tc_rise_at_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TC && $rose(out_q) && !$past(mode_set_i)) |-> (ce_q == '0));

  assert_low_byte_freezes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TC && lo_wr_i) |=> $stable(ce_q));

  assert_oneshot_fall_on_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ONESHOT && $fell(out_q)) |-> $past(rise_i));

  assert_rate_low_one_clock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RATE && !out_q && !mode_set_i) |=> out_q);

  assert_gate_low_high_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RATE && run_q && !level_i && !mode_set_i) |=> out_q);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              gate_i,
  output logic              out_o
);
  localparam int CNT_W = 2 * BYTE_W;

  pit_mode_e        mode, new_mode;
  logic             mode_set, lo_wr, load, level, rise;
  logic [CNT_W-1:0] load_val, cnt_reg, cnt;

  pit_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .gate_i,
    .level_o(level), .rise_o(rise)
  );

  pit_host_if #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_host (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .rd_en_i,
    .cnt_i(cnt), .mode_o(mode), .new_mode_o(new_mode),
    .mode_set_o(mode_set), .lo_wr_o(lo_wr), .load_o(load),
    .load_val_o(load_val), .cnt_reg_o(cnt_reg), .rd_data_o
  );

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .mode_i(mode), .new_mode_i(new_mode),
    .mode_set_i(mode_set), .lo_wr_i(lo_wr), .load_i(load),
    .load_val_i(load_val), .cnt_reg_i(cnt_reg),
    .level_i(level), .rise_i(rise), .cnt_o(cnt), .out_o
  );
endmodule

// File: tb/pit_channel_test.sv
module pit_channel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0, gate = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       out;

  int    checks = 0, errors = 0;
  string phase = "R1";
  bit    done = 0;

  always #5 clk = ~clk;

  pit_channel uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .gate_i(gate), .out_o(out)
  );

  // behavioural reference
  int          m_mode = 0;
  bit          m_run = 0, m_armed = 0, m_out = 0, m_wptr = 0, m_rptr = 0;
  logic [15:0] m_ce = 0, m_cr = 0;
  logic [7:0]  m_lo = 0, m_rhi = 0;
  bit          g_hist [$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (rst_n) begin
      bit          g_rise, g_lvl, ld, lo_ev;
      logic [15:0] old_cr, old_ce, val;
      g_lvl  = g_hist[1];
      g_rise = g_hist[1] && !g_hist[2];
      old_cr = m_cr;
      old_ce = m_ce;
      ld = 0; lo_ev = 0; val = 0;
      if (wr_en && wr_sel && wr_data[1:0] != 2'd3) begin
        m_mode = int'(wr_data[1:0]);
        m_run = 0; m_armed = 0; m_out = (m_mode != 0);
        m_wptr = 0; m_rptr = 0;
      end else begin
        if (wr_en && !wr_sel) begin
          if (!m_wptr) begin m_lo = wr_data; lo_ev = 1; end
          else begin val = {wr_data, m_lo}; ld = 1; end
          m_wptr = !m_wptr;
        end
        if (m_mode == 0) begin
          if (ld) begin m_ce = val; m_out = 0; m_run = 1; end
          else if (lo_ev) m_run = 0;
          else if (m_run) begin if (m_ce == 1) m_out = 1; m_ce = m_ce - 1; end
        end else if (m_mode == 1) begin
          if (g_rise && m_armed) begin m_ce = old_cr; m_out = 0; m_run = 1; end
          else if (m_run) begin if (m_ce == 1) m_out = 1; m_ce = m_ce - 1; end
          if (ld) m_armed = 1;
        end else begin
          if (ld && !m_run) begin m_ce = val; m_run = 1; end
          else if (m_run) begin
            if (!g_lvl) m_out = 1;
            else if (g_rise || m_ce == 1) begin m_ce = old_cr; m_out = 1; end
            else begin m_out = (m_ce != 2); m_ce = m_ce - 1; end
          end
        end
        if (ld) m_cr = val;
        if (rd_en) begin
          if (!m_rptr) m_rhi = old_ce[15:8];
          m_rptr = !m_rptr;
        end
      end
      g_hist.push_front(gate);
      void'(g_hist.pop_back());
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", phase, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check({7'd0, out}, {7'd0, m_out}, "out_o");
    check(rd_data, m_rptr ? m_rhi : m_ce[7:0], "rd_data_o");
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic wr_count(input logic [15:0] v);
    wr(0, v[7:0]);
    wr(0, v[15:8]);
  endtask

  task automatic rd_pulse();
    rd_en = 1;
    step();
    rd_en = 0;
  endtask

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    check({7'd0, out}, 8'd0, "out_o in reset");
    check(rd_data, 8'd0, "rd_data_o in reset");
    rst_n = 1;
    tick(3);

    phase = "R4";
    wr(1, 8'd0);
    tick(2);
    wr_count(16'd5);
    tick(12);

    phase = "R5";
    wr_count(16'd8);
    tick(3);
    wr(0, 8'd20);
    tick(4);
    wr(0, 8'd0);
    tick(25);

    phase = "R12";
    wr_count(16'h0312);
    tick(2);
    rd_pulse();
    tick(300);
    rd_pulse();
    tick(3);
    rd_pulse();
    tick(2);

    phase = "R2";
    wr(1, 8'd3);
    tick(5);
    wr(1, 8'd2);
    tick(3);
    wr(1, 8'd0);
    tick(3);

    phase = "R3";
    wr_count(16'd0);
    tick(65540);

    phase = "R6";
    wr(1, 8'd1);
    gate = 1; tick(4); gate = 0; tick(4);
    wr_count(16'd6);
    tick(2);
    gate = 1; tick(3); gate = 0; tick(12);

    phase = "R7";
    gate = 1; tick(2); gate = 0; tick(2);
    gate = 1; tick(2); gate = 0; tick(14);

    phase = "R8";
    gate = 1; tick(2); gate = 0; tick(1);
    wr_count(16'd3);
    tick(10);
    gate = 1; tick(2); gate = 0; tick(8);

    phase = "R9";
    gate = 1;
    wr(1, 8'd2);
    tick(5);
    wr_count(16'd4);
    tick(14);

    phase = "R10";
    tick(1);
    wr_count(16'd6);
    tick(20);

    phase = "R11";
    gate = 0; tick(6);
    gate = 1; tick(15);
    gate = 0; tick(2); gate = 1; tick(10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule